// File: doc/BRIEF.md
# E3 Receive Alarm Change Interrupt Register

This block collects alarm and event indications from the receive side of an E3 framer. It keeps one sticky status bit for each of them and combines the bits into a single interrupt line. Three inputs are levels: loss of signal, alarm indication signal (AIS) and out-of-frame. For each level input, a bit is latched whenever the input changes, whether it rises or falls. The remaining inputs are single-cycle event pulses, and each pulse latches its bit:
- frame alignment change,
- the two loss-of-frame transitions,
- trail trace change,
- far-end block error (FEBE),
- far-end receive failure (FERF),
- BIP-8 error,
- framing byte error,
- payload type mismatch.

The microprocessor reads the status through a synchronous port with an address, a read strobe and registered read data. Reading a status register returns its latched bits and clears them in the same cycle. If an event arrives in that same cycle, its bit stays set so the event is not lost. A third address returns the live levels of loss of signal and AIS, and reading it does not clear anything. Each status bit has a per-bit enable that gates only the interrupt output. The enables never affect what is latched.

Top module: `e3_alarm_irq`

## Requirements
- R1: After synchronous reset, both status registers and the read data are zero and `irq_o` is low. Level inputs are taken as low during reset.
- R2: Status register one sits at address 0x14. Its bits are: frame-alignment change at bit 4, out-of-frame at bit 3, loss-of-frame at bit 2, loss of signal at bit 1 and AIS at bit 0. Bits 7 to 5 read as zero.
- R3: The loss-of-signal and AIS bits set when their level input rises and again when it falls. The bit is readable from the clock edge that samples the new level.
- R4: The out-of-frame bit sets when `oof_i` rises (frame lost) and when it falls (frame regained).
- R5: The loss-of-frame bit sets on either `lof_decl_evt_i` or `infrm_evt_i`. The frame-alignment bit sets on `cofa_evt_i`.
- R6: Status register two sits at address 0x15. Its bits are: trail trace change at bit 6, FEBE at bit 4, FERF at bit 3, BIP-8 error at bit 2, framing byte error at bit 1 and payload mismatch at bit 0. Bits 7 and 5 read as zero.
- R7: A read strobe sampled at a clock edge puts the register's latched value on `rd_data_o` at that edge and clears that register. A latched bit stays set until its own register is read, and reading one register leaves the other unchanged.
- R8: An event that arrives in the same cycle as a read of its register is not returned by that read. It is returned by the next read.
- R9: Address 0x11 returns the live AIS level at bit 7 and the live loss-of-signal level at bit 6, with the other bits zero. Reading it clears no status bit.
- R10: `irq_o` is high exactly when some status bit is set and its enable bit is set. Enable bits use the same positions as the status bits. A disabled bit is still latched and readable.
- R11: A read of any other address returns zero and clears nothing.
- R12: A level input that stays constant sets no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| los_i | input | 1 | Loss-of-signal level |
| ais_i | input | 1 | AIS level |
| oof_i | input | 1 | Out-of-frame level |
| cofa_evt_i | input | 1 | Frame alignment change pulse |
| lof_decl_evt_i | input | 1 | Pulse: out-of-frame moved into loss-of-frame |
| infrm_evt_i | input | 1 | Pulse: alignment verification moved into in-frame |
| ttb_evt_i | input | 1 | New trail trace message pulse |
| febe_evt_i | input | 1 | Far-end block error pulse |
| ferf_evt_i | input | 1 | Far-end receive failure pulse |
| bip_err_evt_i | input | 1 | BIP-8 error pulse |
| fbyte_err_evt_i | input | 1 | Framing byte error pulse |
| pld_mis_evt_i | input | 1 | Payload type mismatch pulse |
| irq_en1_i | input | 8 | Interrupt enables for status register one |
| irq_en2_i | input | 8 | Interrupt enables for status register two |
| rd_en_i | input | 1 | Read strobe |
| rd_addr_i | input | 8 | Read address |
| rd_data_o | output | 8 | Registered read data |
| irq_o | output | 1 | Active-high combined interrupt |

## Verification
An event pulse or a level change driven before clock edge N is latched at edge N. From then on it shows on `irq_o` and can be read. A read strobe sampled at edge M returns data at edge M, so the monitor compares at the falling edge after M. The driver pushes each expected byte into a queue when it issues the strobe. The monitor pops that byte only at the half cycle after an edge that saw the strobe. Interrupt checks are made half a cycle after the edge that latched or cleared the bit, which is where the registered status settles.

// File: rtl/e3_irq_pkg.sv
package e3_irq_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 8;
    localparam int N_LVL  = 3;
    localparam int ST1_W  = 5;
    localparam int ST2_W  = 6;

    // Register one, MSB first: cofa(4) oof(3) lof(2) los(1) ais(0)
    typedef struct packed {
        logic cofa;
        logic oof;
        logic lof;
        logic los;
        logic ais;
    } st1_t;

    // Register two content (reserved bits inserted when packing)
    typedef struct packed {
        logic ttb;
        logic febe;
        logic ferf;
        logic bip;
        logic fbyte;
        logic pldmis;
    } st2_t;

    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LIVE,
        SEL_ST1,
        SEL_ST2
    } rsel_e;

    function automatic logic [DATA_W-1:0] pack_st1(input st1_t s);
        return {3'b000, s};
    endfunction

    function automatic logic [DATA_W-1:0] pack_st2(input st2_t s);
        return {1'b0, s.ttb, 1'b0, s.febe, s.ferf, s.bip, s.fbyte, s.pldmis};
    endfunction

    function automatic logic [DATA_W-1:0] pack_live(input logic ais, input logic los);
        return {ais, los, 6'b000000};
    endfunction

endpackage

// File: rtl/level_change_det.sv
module level_change_det #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl_i,
    output logic [N-1:0] lvl_q_o,
    output logic [N-1:0] chg_o
);
    for (genvar g = 0; g < N; g++) begin : g_bit
        logic prev_q;
        always_ff @(posedge clk) begin
            if (rst) prev_q <= 1'b0;
            else     prev_q <= lvl_i[g];
        end
        assign lvl_q_o[g] = prev_q;
        assign chg_o[g]   = lvl_i[g] ^ prev_q;
    end
endmodule

// File: rtl/sticky_bank.sv
module sticky_bank #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] q;

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~{W{clr_i}}) | set_i;
    end

    assign q_o = q;

    // R7
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_i |=> ((q_o & $past(q_o)) == $past(q_o)));

    // R3
    set_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (|set_i) |=> ((q_o & $past(set_i)) == $past(set_i)));

    // R7
    read_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && set_i == '0) |=> (q_o == '0));

    // R8
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && (|set_i)) |=> (q_o == $past(set_i)));
endmodule

// File: rtl/reg_read_port.sv
module reg_read_port
    import e3_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] A_LIVE = 8'h11,
    parameter logic [ADDR_W-1:0] A_ST1  = 8'h14,
    parameter logic [ADDR_W-1:0] A_ST2  = 8'h15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    input  logic [DATA_W-1:0] live_i,
    input  logic [DATA_W-1:0] st1_i,
    input  logic [DATA_W-1:0] st2_i,
    output logic              clr1_o,
    output logic              clr2_o,
    output logic [DATA_W-1:0] rd_data_o
);
    rsel_e             sel;
    logic [DATA_W-1:0] mux;

    always_comb begin
        if      (rd_addr_i == A_LIVE) sel = SEL_LIVE;
        else if (rd_addr_i == A_ST1)  sel = SEL_ST1;
        else if (rd_addr_i == A_ST2)  sel = SEL_ST2;
        else                          sel = SEL_NONE;
    end

    always_comb begin
        case (sel)
            SEL_LIVE: mux = live_i;
            SEL_ST1:  mux = st1_i;
            SEL_ST2:  mux = st2_i;
            default:  mux = '0;
        endcase
    end

    assign clr1_o = rd_en_i && (sel == SEL_ST1);
    assign clr2_o = rd_en_i && (sel == SEL_ST2);

    always_ff @(posedge clk) begin
        if (rst)          rd_data_o <= '0;
        else if (rd_en_i) rd_data_o <= mux;
        else              rd_data_o <= '0;
    end

    // R6
    st2_reserved_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en_i && rd_addr_i == A_ST2) |=> (rd_data_o[7] == 1'b0 && rd_data_o[5] == 1'b0));
endmodule

// File: rtl/e3_alarm_irq.sv
module e3_alarm_irq
    import e3_irq_pkg::*;
#(
    parameter logic [ADDR_W-1:0] A_LIVE = 8'h11,
    parameter logic [ADDR_W-1:0] A_ST1  = 8'h14,
    parameter logic [ADDR_W-1:0] A_ST2  = 8'h15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              los_i,
    input  logic              ais_i,
    input  logic              oof_i,
    input  logic              cofa_evt_i,
    input  logic              lof_decl_evt_i,
    input  logic              infrm_evt_i,
    input  logic              ttb_evt_i,
    input  logic              febe_evt_i,
    input  logic              ferf_evt_i,
    input  logic              bip_err_evt_i,
    input  logic              fbyte_err_evt_i,
    input  logic              pld_mis_evt_i,
    input  logic [DATA_W-1:0] irq_en1_i,
    input  logic [DATA_W-1:0] irq_en2_i,
    input  logic              rd_en_i,
    input  logic [ADDR_W-1:0] rd_addr_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic              irq_o
);
    // level bit order: [2]=oof [1]=los [0]=ais
    logic [N_LVL-1:0] lvl_q;
    logic [N_LVL-1:0] lvl_chg;
    st1_t             set1, q1;
    st2_t             set2, q2;
    logic             clr1, clr2;
    logic [DATA_W-1:0] st1_byte, st2_byte, live_byte;

    level_change_det #(.N(N_LVL)) u_lvl (
        .clk     (clk),
        .rst     (rst),
        .lvl_i   ({oof_i, los_i, ais_i}),
        .lvl_q_o (lvl_q),
        .chg_o   (lvl_chg)
    );

    always_comb begin
        set1.cofa = cofa_evt_i;
        set1.oof  = lvl_chg[2];
        set1.lof  = lof_decl_evt_i | infrm_evt_i;
        set1.los  = lvl_chg[1];
        set1.ais  = lvl_chg[0];

        set2.ttb    = ttb_evt_i;
        set2.febe   = febe_evt_i;
        set2.ferf   = ferf_evt_i;
        set2.bip    = bip_err_evt_i;
        set2.fbyte  = fbyte_err_evt_i;
        set2.pldmis = pld_mis_evt_i;
    end

    sticky_bank #(.W(ST1_W)) u_st1 (
        .clk   (clk),
        .rst   (rst),
        .set_i (set1),
        .clr_i (clr1),
        .q_o   (q1)
    );

    sticky_bank #(.W(ST2_W)) u_st2 (
        .clk   (clk),
        .rst   (rst),
        .set_i (set2),
        .clr_i (clr2),
        .q_o   (q2)
    );

    assign st1_byte  = pack_st1(q1);
    assign st2_byte  = pack_st2(q2);
    assign live_byte = pack_live(lvl_q[0], lvl_q[1]);

    reg_read_port #(.A_LIVE(A_LIVE), .A_ST1(A_ST1), .A_ST2(A_ST2)) u_rd (
        .clk       (clk),
        .rst       (rst),
        .rd_en_i   (rd_en_i),
        .rd_addr_i (rd_addr_i),
        .live_i    (live_byte),
        .st1_i     (st1_byte),
        .st2_i     (st2_byte),
        .clr1_o    (clr1),
        .clr2_o    (clr2),
        .rd_data_o (rd_data_o)
    );

    assign irq_o = (|(st1_byte & irq_en1_i)) | (|(st2_byte & irq_en2_i));
endmodule

// File: tb/e3_alarm_irq_bench.sv
module e3_alarm_irq_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic los_i = 0, ais_i = 0, oof_i = 0;
    logic cofa = 0, lofd = 0, infrm = 0;
    logic ttb = 0, febe = 0, ferf = 0, bip = 0, fbyte = 0, pldm = 0;
    logic [7:0] en1 = 8'hFF, en2 = 8'hFF;
    logic       rd_en = 0;
    logic [7:0] rd_addr = 8'h00;
    logic [7:0] rd_data;
    logic       irq;

    int compared = 0;
    int mismatched = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic       mon_due = 1'b0;

    always #4 clk = ~clk;

    e3_alarm_irq u_e3_alarm_irq (
        .clk(clk), .rst(rst),
        .los_i(los_i), .ais_i(ais_i), .oof_i(oof_i),
        .cofa_evt_i(cofa), .lof_decl_evt_i(lofd), .infrm_evt_i(infrm),
        .ttb_evt_i(ttb), .febe_evt_i(febe), .ferf_evt_i(ferf),
        .bip_err_evt_i(bip), .fbyte_err_evt_i(fbyte), .pld_mis_evt_i(pldm),
        .irq_en1_i(en1), .irq_en2_i(en2),
        .rd_en_i(rd_en), .rd_addr_i(rd_addr),
        .rd_data_o(rd_data), .irq_o(irq)
    );

    always @(posedge clk) mon_due <= rd_en;

    // monitor: compares read data half a cycle after the sampling edge
    always @(negedge clk) begin
        if (mon_due && exp_q.size() > 0) begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            compared++;
            if (rd_data !== e) begin
                mismatched++;
                $display("FAIL %s: rd_data=%h expected=%h", t, rd_data, e);
            end
        end
    end

    task automatic do_read(input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(e); tag_q.push_back(t);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic check_irq(input logic e, input string t);
        compared++;
        if (irq !== e) begin
            mismatched++;
            $display("FAIL %s: irq=%b expected=%b", t, irq, e);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        fork
            begin
                repeat (5000) @(posedge clk);
                mismatched++;
                compared++;
                $display("FAIL watchdog: run hung, actual=timeout expected=done");
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
                $finish;
            end
        join_none

        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check_irq(1'b0, "R1 irq after reset");
        do_read(8'h14, 8'h00, "R1 status1 reset");
        do_read(8'h15, 8'h00, "R1 status2 reset");

        // R3 loss of signal rise and fall
        los_i = 1'b1; idle(1);
        check_irq(1'b1, "R10 irq from los");
        do_read(8'h14, 8'h02, "R3 los rise");
        do_read(8'h14, 8'h00, "R7 cleared by read");
        check_irq(1'b0, "R10 irq drops after clear");
        do_read(8'h11, 8'h40, "R9 live los");
        do_read(8'h14, 8'h00, "R9 live read clears nothing new");
        los_i = 1'b0; idle(1);
        do_read(8'h14, 8'h02, "R3 los fall");

        // R3 AIS, R12 stable level
        ais_i = 1'b1; idle(1);
        do_read(8'h14, 8'h01, "R3 ais rise");
        idle(4);
        do_read(8'h14, 8'h00, "R12 stable ais sets nothing");
        do_read(8'h11, 8'h80, "R9 live ais");
        ais_i = 1'b0; idle(1);
        do_read(8'h14, 8'h01, "R3 ais fall");

        // R4 out of frame
        oof_i = 1'b1; idle(1);
        do_read(8'h14, 8'h08, "R4 oof rise");
        oof_i = 1'b0; idle(1);
        do_read(8'h14, 8'h08, "R4 oof fall");

        // R5 pulses
        cofa = 1'b1; idle(1); cofa = 1'b0;
        do_read(8'h14, 8'h10, "R5 cofa");
        lofd = 1'b1; idle(1); lofd = 1'b0;
        do_read(8'h14, 8'h04, "R5 lof declare");
        infrm = 1'b1; idle(1); infrm = 1'b0;
        do_read(8'h14, 8'h04, "R5 lof in-frame");

        // R6 register two, R2 mapping with everything set
        {ttb, febe, ferf, bip, fbyte, pldm} = 6'h3F; idle(1);
        {ttb, febe, ferf, bip, fbyte, pldm} = 6'h00;
        do_read(8'h15, 8'h5F, "R6 status2 all");
        do_read(8'h15, 8'h00, "R6 status2 cleared");
        febe = 1'b1; idle(1); febe = 1'b0;
        do_read(8'h15, 8'h10, "R6 febe bit4");
        cofa = 1; lofd = 1; los_i = 1; ais_i = 1; oof_i = 1; idle(1);
        cofa = 0; lofd = 0;
        do_read(8'h14, 8'h1F, "R2 status1 all");

        // R7 independence of registers
        bip = 1'b1; idle(1); bip = 1'b0;
        do_read(8'h14, 8'h00, "R7 status1 read");
        do_read(8'h15, 8'h04, "R7 status2 untouched");

        // R8 event in the same cycle as a read
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 8'h14; cofa = 1'b1;
        exp_q.push_back(8'h00); tag_q.push_back("R8 same-cycle read");
        @(negedge clk);
        rd_en = 1'b0; cofa = 1'b0;
        do_read(8'h14, 8'h10, "R8 event kept");

        // R10 enable masking
        en1 = 8'h00; en2 = 8'h00;
        pldm = 1'b1; idle(1); pldm = 1'b0;
        check_irq(1'b0, "R10 masked irq");
        en2 = 8'h01; #1;
        check_irq(1'b1, "R10 enabled irq");
        do_read(8'h15, 8'h01, "R10 masked bit latched");
        check_irq(1'b0, "R10 irq after read");

        // R11 unmapped address
        ttb = 1'b1; idle(1); ttb = 1'b0;
        do_read(8'h20, 8'h00, "R11 unmapped reads zero");
        do_read(8'h15, 8'h40, "R11 unmapped clears nothing");

        idle(3);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule